// File: doc/BRIEF.md
# Serial Microphone ADC Capture Controller

This block reads samples from a 12-bit microphone converter over a three-wire serial link: an active-low chip select, a serial clock and one data line from the converter. The serial clock is produced by dividing the system clock by a parameter, which defaults to four (12.5 MHz from 50 MHz). A frame is 16 bits long. The first four bits are leading zeros and are dropped. The last twelve bits, received MSB first, are presented in parallel as an unsigned sample, where mid-scale 2048 stands for silence.

The host controls the block with a `start` level and watches `done`. The `continuous` input is latched at each frame start. With it low, one conversion runs per `start`. `done` then stays high, with chip select high, until the host drops `start`. With it high, frames repeat every `RATE_DIV` system cycles for as long as `start` stays high. For example, 6250 cycles gives 8 kHz at 50 MHz, while the serial clock stays at full speed. `done` then pulses for one cycle per new sample. The sample leaves on a plain `sample`/`done` pair with no ready signal. The block never stalls, so the host must take each word before the next `done` rises.

Top module: `mic_adc_capture`

## Requirements
- R1: Out of reset, and whenever `cs_n` is high, `sclk` is high. Reset also clears `done` and sets `sample` to zero.
- R2: When `start` is high in the idle state and the gap of R10 has elapsed, `cs_n` goes low for exactly `FRAME_BITS*CLK_DIV` system cycles (64 with defaults).
- R3: During a frame, `sclk` has a period of `CLK_DIV` system cycles and shows exactly `FRAME_BITS` (16) rising edges. `sdata` is captured at each rising edge.
- R4: `sample` equals the last `DATA_BITS` (12) bits of the frame, with the first received bit as MSB. `sample` changes in the same cycle that `done` rises.
- R5: The first `FRAME_BITS-DATA_BITS` (4) bits of a frame never reach `sample`, even if they are ones.
- R6: In single mode (`continuous`=0 at frame start), `done` and `cs_n` stay high and no new frame begins while `start` stays high. `done` falls one cycle after `start` is seen low.
- R7: `sample` changes only in a cycle where `done` rises. It holds its value while `done` is high and through the whole next frame.
- R8: In continuous mode with `start` held high, successive falling edges of `cs_n` are exactly `RATE_DIV` cycles apart whenever `RATE_DIV` exceeds one frame plus the gap. Otherwise they are as close as R10 allows.
- R9: In continuous mode, `done` is high for exactly one cycle per sample.
- R10: Between two frames, `cs_n` stays high for at least `CLK_DIV` cycles. A one-shot restart that follows `done` as fast as possible gets exactly `CLK_DIV` (4) cycles.
- R11: Dropping `start` during a continuous frame lets that frame finish and deliver its sample. No further frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request level from the host |
| continuous | input | 1 | 1 = repeat frames at the pacer rate, 0 = one frame per start |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter, idles high |
| sample | output | DATA_BITS (12) | Last captured unsigned sample |
| done | output | 1 | Sample ready: level in single mode, one-cycle pulse in continuous mode |

## Verification
The bench keeps the defaults `CLK_DIV`=4, `FRAME_BITS`=16 and `DATA_BITS`=12, so frame length, edge count and the four-cycle gap are checked at their real values. It lowers `RATE_DIV` from 6250 to 150, so that several continuous periods fit into a short run and their spacing can be measured exactly. A converter model replays queued words, including one whose leading bits are ones. A fast stop-and-restart of `start` brings the minimum chip-select gap within reach.

// File: rtl/mic_cap_pkg.sv
package mic_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_SYNC  = 2'd2
  } cap_state_e;
endpackage

// File: rtl/mic_sclk_gen.sv
// Serial clock divider and bit counter, active only while a frame runs.
module mic_sclk_gen #(
  parameter int CLK_DIV    = 4,
  parameter int FRAME_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic frame_end
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BW   = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

  logic [DW-1:0] div_cnt;
  logic [BW-1:0] bit_cnt;
  logic          wrap;

  assign wrap = (div_cnt == DW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      bit_cnt <= '0;
    end else if (!run) begin
      div_cnt <= '0;
      bit_cnt <= '0;
    end else begin
      div_cnt <= wrap ? '0 : div_cnt + 1'b1;
      if (wrap) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // low half first, high half second; idle high
  assign sclk      = !run || (div_cnt >= DW'(HALF));
  assign rise_tick = run && (div_cnt == DW'(HALF - 1));
  assign frame_end = run && wrap && (bit_cnt == BW'(FRAME_BITS - 1));
endmodule

// File: rtl/mic_shift_in.sv
// Keeps only the newest DATA_BITS bits; leading bits fall off the top.
module mic_shift_in #(
  parameter int DATA_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sdata,
  input  logic                 capture,
  input  logic                 commit,
  output logic [DATA_BITS-1:0] sample
);
  logic [DATA_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      sample <= '0;
    end else begin
      if (capture) shreg <= {shreg[DATA_BITS-2:0], sdata};
      if (commit)  sample <= shreg;
    end
  end
endmodule

// File: rtl/mic_pacer.sv
// Sample-rate pacer and minimum chip-select gap timer, both saturating.
module mic_pacer #(
  parameter int RATE_DIV = 6250,
  parameter int GAP_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_go,
  input  logic sync_enter,
  output logic rate_due,
  output logic gap_done
);
  localparam int PW = (RATE_DIV > 1) ? $clog2(RATE_DIV) : 1;
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

  logic [PW-1:0] pace_cnt;
  logic [GW-1:0] gap_cnt;

  assign rate_due = (pace_cnt == PW'(RATE_DIV - 1));
  assign gap_done = (gap_cnt == GW'(GAP_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pace_cnt <= '0;
      gap_cnt  <= GW'(GAP_CYC - 1);
    end else begin
      if (frame_go)      pace_cnt <= '0;
      else if (!rate_due) pace_cnt <= pace_cnt + 1'b1;

      if (sync_enter)    gap_cnt <= '0;
      else if (!gap_done) gap_cnt <= gap_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mic_adc_capture.sv
module mic_adc_capture #(
  parameter int CLK_DIV    = 4,
  parameter int FRAME_BITS = 16,
  parameter int DATA_BITS  = 12,
  parameter int RATE_DIV   = 6250
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 continuous,
  input  logic                 sdata,
  output logic                 cs_n,
  output logic                 sclk,
  output logic [DATA_BITS-1:0] sample,
  output logic                 done
);
  import mic_cap_pkg::*;

  localparam int GAP_CYC = CLK_DIV;

  cap_state_e state_q;
  logic mode_q, done_q;
  logic run, rise_tick, frame_end, rate_due, gap_done, frame_go;

  assign run = (state_q == ST_SHIFT);
  assign frame_go = start && gap_done &&
                    ((state_q == ST_IDLE) ||
                     ((state_q == ST_SYNC) && mode_q && rate_due));

  mic_sclk_gen #(.CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS)) i_sclk (
    .clk(clk), .rst_n(rst_n), .run(run),
    .sclk(sclk), .rise_tick(rise_tick), .frame_end(frame_end)
  );

  mic_shift_in #(.DATA_BITS(DATA_BITS)) i_shift (
    .clk(clk), .rst_n(rst_n), .sdata(sdata),
    .capture(rise_tick), .commit(frame_end), .sample(sample)
  );

  mic_pacer #(.RATE_DIV(RATE_DIV), .GAP_CYC(GAP_CYC)) i_pacer (
    .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .sync_enter(frame_end),
    .rate_due(rate_due), .gap_done(gap_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (frame_go) begin
            state_q <= ST_SHIFT;
            mode_q  <= continuous;
          end
        end
        ST_SHIFT: begin
          if (frame_end) begin
            state_q <= ST_SYNC;
            done_q  <= 1'b1;
          end
        end
        ST_SYNC: begin
          if (!start) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
          end else begin
            if (mode_q) done_q <= 1'b0;
            if (frame_go) begin
              state_q <= ST_SHIFT;
              mode_q  <= continuous;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n = !run;
  assign done = done_q;
endmodule

// File: rtl/mic_adc_capture_chk.sv
module mic_adc_capture_chk #(
  parameter int CLK_DIV    = 4,
  parameter int FRAME_BITS = 16,
  parameter int DATA_BITS  = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 sclk,
  input logic                 done,
  input logic [DATA_BITS-1:0] sample
);
  logic        cs_n_q, sclk_q, seen;
  int unsigned rise_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q   <= 1'b1;
      sclk_q   <= 1'b1;
      seen     <= 1'b0;
      rise_cnt <= 0;
      hi_cnt   <= 0;
    end else begin
      cs_n_q <= cs_n;
      sclk_q <= sclk;
      if (!cs_n && cs_n_q) begin
        seen     <= 1'b1;
        rise_cnt <= 0;
      end else if (!cs_n && sclk && !sclk_q) begin
        rise_cnt <= rise_cnt + 1;
      end
      if (cs_n) hi_cnt <= (hi_cnt < 1000) ? hi_cnt + 1 : hi_cnt;
      else      hi_cnt <= 0;
    end
  end

  // R1
  cs_idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  // R6
  done_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);

  // R7
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done) |-> $stable(sample));

  // R3
  frame_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !cs_n_q && seen) |-> (rise_cnt == FRAME_BITS));

  // R10
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs_n_q && seen) |-> (hi_cnt >= CLK_DIV));
endmodule

bind mic_adc_capture mic_adc_capture_chk #(
  .CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS), .DATA_BITS(DATA_BITS)
) i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
  .done(done), .sample(sample)
);

// File: tb/test_mic_adc_capture.sv
module test_mic_adc_capture;
  localparam int CLK_DIV = 4;
  localparam int FRAME_BITS = 16;
  localparam int DATA_BITS = 12;
  localparam int RATE_DIV = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic continuous = 1'b0;
  logic sdata = 1'b0;
  logic cs_n, sclk, done;
  logic [DATA_BITS-1:0] sample;

  int total = 0;
  int bad = 0;

  mic_adc_capture #(
    .CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS),
    .DATA_BITS(DATA_BITS), .RATE_DIV(RATE_DIV)
  ) i_mic_adc_capture (
    .clk(clk), .rst_n(rst_n), .start(start), .continuous(continuous),
    .sdata(sdata), .cs_n(cs_n), .sclk(sclk), .sample(sample), .done(done)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard queues
  logic [FRAME_BITS-1:0] adc_q[$];
  logic [DATA_BITS-1:0]  exp_q[$];

  task automatic push_word(logic [FRAME_BITS-1:0] w);
    adc_q.push_back(w);
    exp_q.push_back(w[DATA_BITS-1:0]);
  endtask

  // converter model: first bit at chip-select fall, next bit on each sclk fall
  logic [FRAME_BITS-1:0] cur_word = '0;
  int bit_idx = FRAME_BITS - 1;
  logic m_cs_q = 1'b1, m_sclk_q = 1'b1;
  always @(negedge clk) begin
    if (m_cs_q && !cs_n) begin
      cur_word = (adc_q.size() > 0) ? adc_q.pop_front() : '0;
      bit_idx = FRAME_BITS - 1;
    end else if (!cs_n && m_sclk_q && !sclk && bit_idx > 0) begin
      bit_idx--;
    end
    sdata = cur_word[bit_idx];
    m_cs_q = cs_n;
    m_sclk_q = sclk;
  end

  // monitor: measurements and scoreboard pops
  int cs_lo_run = 0, cs_hi_run = 0, rises = 0;
  int last_frame_len = 0, last_rises = 0, last_gap = 0;
  int since_fall = 0, last_period = 0, cs_falls = 0;
  int done_run = 0, last_done_width = 0, done_rises = 0;
  logic cs_p = 1'b1, sclk_p = 1'b1, done_p = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n) begin
        if (cs_p) begin
          last_gap = cs_hi_run;
          last_period = since_fall;
          since_fall = 1;
          cs_falls++;
          cs_lo_run = 1;
          rises = 0;
        end else begin
          cs_lo_run++;
          since_fall++;
          if (sclk && !sclk_p) rises++;
        end
      end else begin
        since_fall++;
        if (!cs_p) begin
          last_frame_len = cs_lo_run;
          last_rises = rises;
          cs_hi_run = 1;
        end else cs_hi_run++;
      end
      if (done) begin
        if (!done_p) begin
          done_rises++;
          done_run = 1;
          if (exp_q.size() == 0) chk("R4 unexpected sample", int'(sample), -1);
          else chk("R4/R5 sample value", int'(sample), int'(exp_q.pop_front()));
        end else done_run++;
      end else if (done_p) begin
        last_done_width = done_run;
      end
      cs_p = cs_n;
      sclk_p = sclk;
      done_p = done;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_rises(int n);
    for (int t = 0; t < 2000 && done_rises < n; t++) step();
  endtask

  task automatic wait_cs_low();
    for (int t = 0; t < 2000 && cs_n; t++) step();
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  int falls_snap;

  initial begin
    repeat (3) step();
    // R1 reset state
    chk("R1 cs_n in reset", int'(cs_n), 1);
    chk("R1 sclk in reset", int'(sclk), 1);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 sample in reset", int'(sample), 0);
    rst_n = 1'b1;
    repeat (3) step();

    // single conversion: R2, R3, R4
    push_word(16'h0ABC);
    start = 1'b1;
    wait_rises(1);
    chk("R2 frame length", last_frame_len, FRAME_BITS * CLK_DIV);
    chk("R3 sclk rising edges", last_rises, FRAME_BITS);
    // R6 hold while start high
    repeat (20) step();
    chk("R6 done held", int'(done), 1);
    chk("R6 cs_n held high", int'(cs_n), 1);
    chk("R1 sclk idle high", int'(sclk), 1);
    chk("R6 no second frame", cs_falls, 1);
    start = 1'b0;
    step();
    chk("R6 done drops after start low", int'(done), 0);

    // R5 leading ones ignored, then fastest restart for R10 and R7
    push_word(16'hF123);
    start = 1'b1;
    wait_rises(2);
    push_word(16'h0800);
    start = 1'b0;
    step();
    start = 1'b1;
    wait_cs_low();
    chk("R10 minimum gap", last_gap, CLK_DIV);
    repeat (20) step();
    chk("R7 sample held during frame", int'(sample), 'h123);
    wait_rises(3);
    start = 1'b0;
    repeat (10) step();

    // continuous mode: R8, R9, R11
    push_word(16'h0000);
    push_word(16'h0FFF);
    push_word(16'h0555);
    push_word(16'h0AAA);
    push_word(16'h0001);
    push_word(16'h0F00);
    continuous = 1'b1;
    start = 1'b1;
    wait_rises(8);
    chk("R8 frame period", last_period, RATE_DIV);
    chk("R9 done pulse width", last_done_width, 1);
    wait_cs_low();
    repeat (10) step();
    start = 1'b0;
    falls_snap = cs_falls;
    wait_rises(9);
    repeat (400) step();
    chk("R11 no frame after stop", cs_falls, falls_snap);
    chk("R11 last frame delivered", done_rises, 9);
    chk("R11 cs_n idle", int'(cs_n), 1);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule